// File: doc/BRIEF.md
# Winding Tone Generator

The block makes a three-phase motor bridge give an audible beep by pulsing one high-side switch while the other two phases are held on their low-side switches. A request carries a tone frequency in Hz and a length in milliseconds. Both values are clamped to safe ranges. A sequential divider then works out the half-period of the tone in 100 ns units. Each tone cycle drives a short high pulse, which is 1% of the half-period and never longer than 20 µs. The rest of the half-period is spent with all three phases low. Cycles repeat until the requested length has elapsed.

Timing follows a `unit_tick` clock enable that marks 100 ns units. The phase that gets pulsed rotates from one beep to the next, so a single failed switch cannot silence every beep. When pulsing ends, all switches are released (floating). `busy` stays high for a further settling interval so that the motor controller does not start a spinup straight away. No request is accepted while the motor is running or while a beep is in progress.

Top module: `beep_gen`

## Requirements
- R1: After reset `busy` is 0 and every phase floats (`hs_on` = 0, `ls_on` = 0). Whenever `busy` is 0 every phase floats.
- R2: The frequency is clamped to 100..5000 Hz before use.
- R3: The duration is clamped to 1..5000 ms before use.
- R4: The half-period in units is (10,000,000 / f) / 2, with integer division. One tone cycle (high pulse plus low gap) lasts exactly this many units.
- R5: The high pulse lasts min(half/100, 200) units. The low gap lasts half minus that.
- R6: The end test is made at the end of each cycle: pulsing stops once the elapsed units reach duration × UNITS_PER_MS. The pulse count is therefore max(1, ceil(dur_units / half)).
- R7: From acceptance until pulsing ends, all three phases are driven. Every phase that is not pulsed high has `ls_on` = 1, and this includes the time spent dividing.
- R8: Bit i of `hs_on` / `ls_on` is phase i. The pulsed phase is 2, 0, 1, 2, 0, 1... for successive accepted beeps. A hidden selector starts at 0, the high phase is (sel+2) mod 3, and sel advances by 4 modulo 3 after each beep.
- R9: `start` is ignored while `motor_run` = 1 or while `busy` = 1. An ignored start neither begins a beep nor advances the phase rotation.
- R10: After the last cycle all phases float with `busy` = 1 for SETTLE_MS × UNITS_PER_MS units, and then `busy` falls.
- R11: No phase ever has `hs_on` and `ls_on` both set, and at most one `hs_on` bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| unit_tick | input | 1 | Clock enable, one per 100 ns unit |
| start | input | 1 | Beep request strobe |
| motor_run | input | 1 | Motor active; blocks requests |
| freq_hz | input | 16 | Tone frequency in Hz |
| dur_ms | input | 16 | Tone length in ms |
| hs_on | output | 3 | High-side switch on, per phase |
| ls_on | output | 3 | Low-side switch on, per phase |
| busy | output | 1 | Beep or settling in progress |

## Verification
The tones cover both sides of each clamp. A frequency of 20000 Hz must behave like 5000 Hz, 50 Hz must behave like 100 Hz, and a duration of 0 ms must behave like 1 ms. The 100 Hz tone is the only one where the 20 µs cap on the pulse width takes effect; the other tones separate the 1% rule from the cap. Durations are chosen so that 1, 2 and 3 cycles result, including one where the duration is not a whole number of half-periods, which shows that a cycle always runs to its end. Blocked requests, both from `motor_run` and from a start issued mid-beep, are placed between beeps, so that the pulsed phase of the next beep shows whether the rotation advanced.

// File: rtl/beep_pkg.sv
package beep_pkg;
  localparam int unsigned F_LO     = 100;
  localparam int unsigned F_HI     = 5000;
  localparam int unsigned D_LO     = 1;
  localparam int unsigned D_HI     = 5000;
  localparam int unsigned UNITS_PS = 10_000_000;
  localparam int unsigned ON_CAP   = 200;

  typedef enum logic [2:0] {ST_IDLE, ST_DIV, ST_ON, ST_OFF, ST_SETTLE} beep_st_t;

  function automatic logic [15:0] clamp16(input logic [15:0] v, input logic [15:0] lo,
                                          input logic [15:0] hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  // pulse width: one percent of the half-period, capped
  function automatic logic [15:0] on_units(input logic [15:0] half);
    logic [15:0] pct;
    pct = half / 16'd100;
    return (pct > 16'(ON_CAP)) ? 16'(ON_CAP) : pct;
  endfunction

  // selector step of four, reduced modulo three
  function automatic logic [1:0] sel_step(input logic [1:0] s);
    return (s == 2'd2) ? 2'd0 : s + 2'd1;
  endfunction

  function automatic logic [1:0] high_of(input logic [1:0] s);
    return (s == 2'd0) ? 2'd2 : s - 2'd1;
  endfunction
endpackage

// File: rtl/beep_divider.sv
module beep_divider #(
  parameter int NUM_W = 24,
  parameter int DEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             done,
  output logic [NUM_W-1:0] quot
);
  localparam int CW = $clog2(NUM_W + 1);

  logic [DEN_W-1:0] rem, den_q;
  logic [NUM_W-1:0] nsh;
  logic [CW-1:0]    cnt;
  logic             running;
  logic [DEN_W:0]   trial, diff;

  always_comb begin
    trial = {rem, nsh[NUM_W-1]};
    diff  = trial - {1'b0, den_q};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem <= '0; den_q <= '0; nsh <= '0; quot <= '0;
      cnt <= '0; running <= 1'b0; done <= 1'b0;
    end else if (go) begin
      rem <= '0; den_q <= den; nsh <= num; quot <= '0;
      cnt <= CW'(NUM_W); running <= 1'b1; done <= 1'b0;
    end else if (running) begin
      if (trial >= {1'b0, den_q}) begin
        rem  <= diff[DEN_W-1:0];
        quot <= {quot[NUM_W-2:0], 1'b1};
      end else begin
        rem  <= trial[DEN_W-1:0];
        quot <= {quot[NUM_W-2:0], 1'b0};
      end
      nsh <= nsh << 1;
      cnt <= cnt - CW'(1);
      if (cnt == CW'(1)) begin
        running <= 1'b0;
        done    <= 1'b1;
      end
    end else begin
      done <= 1'b0;
    end
  end
endmodule

// File: rtl/beep_roles.sv
module beep_roles (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       adv,
  output logic [1:0] hi_idx
);
  import beep_pkg::*;
  logic [1:0] sel;

  always_ff @(posedge clk) begin
    if (!rst_n)   sel <= 2'd0;
    else if (adv) sel <= sel_step(sel);
  end

  assign hi_idx = high_of(sel);
endmodule

// File: rtl/beep_gen.sv
module beep_gen #(
  parameter int UNITS_PER_MS = 10000,
  parameter int SETTLE_MS    = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        unit_tick,
  input  logic        start,
  input  logic        motor_run,
  input  logic [15:0] freq_hz,
  input  logic [15:0] dur_ms,
  output logic [2:0]  hs_on,
  output logic [2:0]  ls_on,
  output logic        busy
);
  import beep_pkg::*;

  localparam int TOTAL_W      = $clog2(D_HI * UNITS_PER_MS + 1);
  localparam int SETTLE_UNITS = SETTLE_MS * UNITS_PER_MS;
  localparam int SET_W        = $clog2(SETTLE_UNITS + 1);

  beep_st_t             state;
  logic [TOTAL_W-1:0]   dur_units, elapsed, elapsed_inc;
  logic [15:0]          on_r, off_r, seg_cnt, half_w, on_w;
  logic [SET_W-1:0]     set_cnt;
  logic [23:0]          quot;
  logic [31:0]          dur_prod;
  logic [1:0]           hi_idx;

  // named internal events
  logic accept, div_done, on_end, off_end, beep_stop, settle_end;

  assign accept      = start && !motor_run && (state == ST_IDLE);
  assign elapsed_inc = elapsed + TOTAL_W'(1);
  assign on_end      = (state == ST_ON)  && unit_tick && (seg_cnt == on_r - 16'd1);
  assign off_end     = (state == ST_OFF) && unit_tick && (seg_cnt == off_r - 16'd1);
  assign beep_stop   = off_end && (elapsed_inc >= dur_units);
  assign settle_end  = (state == ST_SETTLE) && unit_tick &&
                       (set_cnt == SET_W'(SETTLE_UNITS - 1));
  assign half_w      = 16'(quot >> 1);
  assign on_w        = on_units(half_w);
  assign dur_prod    = 32'(clamp16(dur_ms, 16'(D_LO), 16'(D_HI))) * 32'(UNITS_PER_MS);

  beep_divider #(.NUM_W(24), .DEN_W(16)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .go    (accept),
    .num   (24'(UNITS_PS)),
    .den   (clamp16(freq_hz, 16'(F_LO), 16'(F_HI))),
    .done  (div_done),
    .quot  (quot)
  );

  beep_roles u_roles (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv    (beep_stop),
    .hi_idx (hi_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE; dur_units <= '0; elapsed <= '0;
      on_r <= '0; off_r <= '0; seg_cnt <= '0; set_cnt <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          dur_units <= TOTAL_W'(dur_prod);
          state     <= ST_DIV;
        end
        ST_DIV: if (div_done) begin
          on_r    <= on_w;
          off_r   <= half_w - on_w;
          elapsed <= '0;
          seg_cnt <= '0;
          state   <= ST_ON;
        end
        ST_ON: if (unit_tick) begin
          elapsed <= elapsed_inc;
          if (on_end) begin seg_cnt <= '0; state <= ST_OFF; end
          else seg_cnt <= seg_cnt + 16'd1;
        end
        ST_OFF: if (unit_tick) begin
          elapsed <= elapsed_inc;
          if (off_end) begin
            seg_cnt <= '0;
            set_cnt <= '0;
            state   <= beep_stop ? ST_SETTLE : ST_ON;
          end else seg_cnt <= seg_cnt + 16'd1;
        end
        ST_SETTLE: if (unit_tick) begin
          if (settle_end) state <= ST_IDLE;
          else set_cnt <= set_cnt + SET_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);

  always_comb begin
    for (int p = 0; p < 3; p++) begin
      hs_on[p] = 1'b0;
      ls_on[p] = 1'b0;
      case (state)
        ST_DIV, ST_OFF: ls_on[p] = 1'b1;
        ST_ON: begin
          hs_on[p] = (hi_idx == 2'(p));
          ls_on[p] = (hi_idx != 2'(p));
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/beep_gen_chk.sv
module beep_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       motor_run,
  input logic [2:0] hs_on,
  input logic [2:0] ls_on,
  input logic       busy,
  input logic       beep_stop,
  input logic       div_done
);
  assert_idle_float_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (hs_on == 3'b000 && ls_on == 3'b000));

  assert_no_shoot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_on & ls_on) == 3'b000);

  assert_one_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hs_on));

  assert_all_driven_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (hs_on | ls_on) != 3'b000) |-> ((hs_on | ls_on) == 3'b111));

  assert_div_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    div_done |-> (ls_on == 3'b111 && hs_on == 3'b000));

  assert_ignore_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && motor_run && !busy) |=> !busy);

  assert_stop_float_R10: assert property (@(posedge clk) disable iff (!rst_n)
    beep_stop |=> (busy && hs_on == 3'b000 && ls_on == 3'b000));

  assert_fall_float_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(hs_on == 3'b000 && ls_on == 3'b000));
endmodule

bind beep_gen beep_gen_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .motor_run (motor_run),
  .hs_on     (hs_on),
  .ls_on     (ls_on),
  .busy      (busy),
  .beep_stop (beep_stop),
  .div_done  (div_done)
);

// File: tb/beep_gen_bench.sv
`timescale 1ns/1ps
module beep_gen_bench;
  localparam int UPM = 200;
  localparam int SMS = 2;

  logic clk = 1'b0, rst_n = 1'b0, unit_tick = 1'b1, start = 1'b0, motor_run = 1'b0;
  logic [15:0] freq_hz = '0, dur_ms = '0;
  logic [2:0] hs_on, ls_on;
  logic busy;
  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done_flag = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  beep_gen #(.UNITS_PER_MS(UPM), .SETTLE_MS(SMS)) u_beep_gen (
    .clk(clk), .rst_n(rst_n), .unit_tick(unit_tick), .start(start),
    .motor_run(motor_run), .freq_hz(freq_hz), .dur_ms(dur_ms),
    .hs_on(hs_on), .ls_on(ls_on), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int clampi(input int v, input int lo, input int hi);
    return (v < lo) ? lo : (v > hi) ? hi : v;
  endfunction

  // one beep: start, observe to the fall of busy, compare with expectations
  task automatic run_beep(input int f, input int d, input bit poke, input int exp_hi,
                          input string tag);
    int fc = clampi(f, 100, 5000);
    int dc = clampi(d, 1, 5000);
    int half = (10_000_000 / fc) / 2;
    int on = (half / 100 > 200) ? 200 : half / 100;
    int n_exp = (dc * UPM + half - 1) / half;
    int n = 0, width = 0, len = 0, first_len = -1, settle = 0, hi_seen = -1;
    int undriven = 0, clash = 0, i = 0;
    bit prev_h = 1'b0;
    if (n_exp < 1) n_exp = 1;
    freq_hz = 16'(f); dur_ms = 16'(d);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, {"R9 accepted ", tag}, busy, 1);
    while (busy && !done_flag) begin
      if (poke && i == 20) start = 1'b1;
      else start = 1'b0;
      if ((hs_on & ls_on) != 3'b000 || !$onehot0(hs_on)) clash++;
      if ((hs_on | ls_on) != 3'b000 && (hs_on | ls_on) != 3'b111) undriven++;
      if (|hs_on && !prev_h) begin
        n++;
        if (n == 1) begin
          for (int p = 0; p < 3; p++) if (hs_on[p]) hi_seen = p;
        end else if (n == 2 && first_len < 0) first_len = len;
      end
      if (n == 1 && first_len < 0) begin
        if (hs_on == 3'b000 && ls_on == 3'b000) first_len = len;
        else len++;
      end
      if (n == 1 && |hs_on) width++;
      if (hs_on == 3'b000 && ls_on == 3'b000) settle++;
      prev_h = |hs_on;
      i++;
      @(negedge clk);
    end
    start = 1'b0;
    chk(n == n_exp, {"R6 pulse count ", tag}, n, n_exp);
    chk(width == on, {"R5 pulse width ", tag}, width, on);
    chk(first_len == half, {"R4 cycle length ", tag}, first_len, half);
    chk(hi_seen == exp_hi, {"R8 pulsed phase ", tag}, hi_seen, exp_hi);
    chk(settle == SMS * UPM, {"R10 settle units ", tag}, settle, SMS * UPM);
    chk(undriven == 0, {"R7 all driven ", tag}, undriven, 0);
    chk(clash == 0, {"R11 switch pairs ", tag}, clash, 0);
  endtask

  task automatic t_reset;
    chk(busy == 1'b0, "R1 busy at reset", busy, 0);
    chk(hs_on == 3'b000 && ls_on == 3'b000, "R1 floating at reset", {hs_on, ls_on}, 0);
  endtask

  task automatic t_motor_block;
    motor_run = 1'b1; freq_hz = 16'd1000; dur_ms = 16'd1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 30; k++) begin
      if (busy || hs_on != 3'b000 || ls_on != 3'b000) begin
        chk(1'b0, "R9 start ignored while motor runs", {busy, hs_on, ls_on}, 0);
        break;
      end
      @(negedge clk);
    end
    chk(busy == 1'b0, "R9 still idle after blocked start", busy, 0);
    motor_run = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    run_beep(5000, 1, 1'b0, 2, "f5000 d1");
    t_motor_block();
    run_beep(20000, 10, 1'b0, 0, "R2 f20000 clamps to 5000");
    run_beep(2000, 13, 1'b1, 1, "f2000 d13 with start mid-beep");
    run_beep(3000, 0, 1'b0, 2, "R3 d0 clamps to 1");
    run_beep(50, 1, 1'b0, 0, "R2 f50 clamps to 100, R5 cap");
    run_beep(5000, 11, 1'b0, 1, "f5000 d11");
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    wait (cyc >= 190_000);
    if (!done_flag) begin
      done_flag = 1'b1;
      chk(1'b0, "watchdog", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule